// File: doc/BRIEF.md
# Framed Request Message Parser

This block sits behind a reliable byte transport and turns a stream of request messages into one decoded request at a time. Each message opens with a fixed start byte (0xA5). Then come a 32-bit operation identifier and a 32-bit content length, each sent most significant byte first. The content bytes follow, and a fixed end byte (0x5A) closes the message. While the content streams past, the parser picks out the operands that the identifier calls for: a 32-bit address, a 32-bit repeat count and a one-byte value. It then offers them to a downstream executor.

A start byte of the wrong value means the peer is not speaking the protocol, so the parser raises a connection-close pulse. A wrong end byte, or an identifier outside the known set, raises a protocol-error pulse instead. In every one of these cases the parser drops the message and goes back to looking for a start byte. A finished request is held stable, and the byte input is stalled, until the executor acknowledges it.

Top module: `req_frame_parser`

## Requirements
- R1: After reset, `in_ready` is 1 and `req_valid`, `close_conn` and `proto_err` are 0.
- R2: When the parser is looking for a message and accepts a byte other than 0xA5, `close_conn` is 1 for exactly the next cycle. `proto_err` stays 0, and a following well-formed message is still decoded.
- R3: The identifier and the length are taken from the four bytes each that follow the start byte, most significant byte first. `req_id` reports the full 32-bit identifier.
- R4: For identifiers 1 and 5, content bytes 0..3 form `req_addr` (first byte most significant) and content byte 4 is `req_value`. `req_count` is 0.
- R5: For identifier 2, content bytes 0..3 form `req_addr`. `req_count` and `req_value` are 0.
- R6: For identifier 3, content bytes 0..3 form `req_addr` and bytes 4..7 form `req_count`, most significant byte first. `req_value` is 0.
- R7: For identifier 10, content bytes 0..3 form `req_addr`, bytes 4..7 form `req_count` and byte 8 is `req_value`.
- R8: Content bytes beyond the operands, and all content of identifiers 0, 4 and 6..9, are consumed as the length field directs and discarded. Operand fields not filled by the content read as 0.
- R9: If the byte in the end position is not 0x5A, `proto_err` is 1 for exactly the next cycle, no request is presented, and the parser hunts for a start byte again.
- R10: An identifier above 10 sets `proto_err` for one cycle, in the cycle after the last length byte. No request follows, and the parser returns to hunting for a start byte.
- R11: A decoded request appears on `req_valid` in the cycle after the end byte. It and its fields then hold, with `in_ready` at 0, until `req_ack` is sampled high. After that `req_valid` is 0 and `in_ready` is 1, and no byte offered during the hold has been consumed.
- R12: A length of 0 makes the byte right after the length field the end byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is offered on `in_data` |
| in_data | input | 8 | Incoming stream byte |
| in_ready | output | 1 | Parser will take the offered byte this cycle |
| req_valid | output | 1 | A decoded request is presented |
| req_ack | input | 1 | Executor takes the presented request |
| req_id | output | 32 | Operation identifier of the request |
| req_addr | output | 32 | Decoded address operand |
| req_count | output | 32 | Decoded repeat count operand |
| req_value | output | 8 | Decoded value byte |
| close_conn | output | 1 | One-cycle pulse: bad start byte, drop the connection |
| proto_err | output | 1 | One-cycle pulse: bad end byte or unknown identifier |

## Verification
Every result is one register away from the byte that causes it. The close pulse follows a rejected start byte in the next cycle. The error pulse follows the last length byte, or a wrong end byte, in the next cycle. The request appears in the cycle after the end byte and drops in the cycle after the acknowledge is sampled. The bench offers each byte at a falling edge and withdraws it at the next falling edge, so exactly one rising edge takes it. It then reads the outputs at that second falling edge, which is the cycle the byte's result is due. The pulse flags are read again one cycle later to confirm they last a single cycle. The sweep covers identifiers 0 to 10 and one unknown identifier, each at content lengths from 0 to 12, with expected operands built from the byte pattern the bench sent.

// File: rtl/rf_pkg.sv
package rf_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_ID,
        ST_LEN,
        ST_BODY,
        ST_TAIL,
        ST_HOLD
    } rf_state_e;

    localparam logic [7:0] RF_SOF = 8'hA5;
    localparam logic [7:0] RF_EOF = 8'h5A;

    localparam int OP_BYTE_WRITE    = 1;
    localparam int OP_BYTE_READ     = 2;
    localparam int OP_STREAM_READ   = 3;
    localparam int OP_BYTE_POLL     = 5;
    localparam int OP_STREAM_DELETE = 10;
    localparam int OP_LAST_KNOWN    = 10;

endpackage

// File: rtl/rf_byte_shift.sv
// Shifts one byte into the low end of a most-significant-first accumulator.
module rf_byte_shift #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [7:0]   din,
    output logic [W-1:0] nxt
);
    generate
        if (W > 8) begin : g_wide
            assign nxt = {cur[W-9:0], din};
        end else begin : g_narrow
            logic [7:0] unused_cur;
            assign unused_cur = 8'(cur);
            assign nxt        = din[W-1:0];
        end
    endgenerate
endmodule

// File: rtl/rf_op_layout.sv
// Content layout per operation identifier.
module rf_op_layout #(
    parameter int ID_W   = 32,
    parameter int LEN_W  = 32,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic [ID_W-1:0]  op_id,
    output logic             known,
    output logic             has_addr,
    output logic             has_count,
    output logic             has_value,
    output logic [LEN_W-1:0] value_pos
);
    import rf_pkg::*;

    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int CNT_BYTES  = CNT_W / 8;

    always_comb begin
        known     = (op_id <= ID_W'(OP_LAST_KNOWN));
        has_addr  = 1'b0;
        has_count = 1'b0;
        has_value = 1'b0;
        value_pos = '0;
        if (op_id == ID_W'(OP_BYTE_WRITE) || op_id == ID_W'(OP_BYTE_POLL)) begin
            has_addr  = 1'b1;
            has_value = 1'b1;
            value_pos = LEN_W'(ADDR_BYTES);
        end else if (op_id == ID_W'(OP_BYTE_READ)) begin
            has_addr  = 1'b1;
        end else if (op_id == ID_W'(OP_STREAM_READ)) begin
            has_addr  = 1'b1;
            has_count = 1'b1;
        end else if (op_id == ID_W'(OP_STREAM_DELETE)) begin
            has_addr  = 1'b1;
            has_count = 1'b1;
            has_value = 1'b1;
            value_pos = LEN_W'(ADDR_BYTES + CNT_BYTES);
        end
    end
endmodule

// File: rtl/req_frame_parser.sv
module req_frame_parser #(
    parameter int ID_W   = 32,
    parameter int LEN_W  = 32,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32,
    parameter int VAL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              req_valid,
    input  logic              req_ack,
    output logic [ID_W-1:0]   req_id,
    output logic [ADDR_W-1:0] req_addr,
    output logic [CNT_W-1:0]  req_count,
    output logic [VAL_W-1:0]  req_value,
    output logic              close_conn,
    output logic              proto_err
);
    import rf_pkg::*;

    localparam int ID_BYTES   = ID_W / 8;
    localparam int LEN_BYTES  = LEN_W / 8;
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int CNT_BYTES  = CNT_W / 8;
    localparam int IDX_W      = 4;

    typedef struct packed {
        rf_state_e         state;
        logic [IDX_W-1:0]  idx;
        logic [LEN_W-1:0]  pos;
        logic [ID_W-1:0]   id;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  count;
        logic [VAL_W-1:0]  value;
        logic              close;
        logic              err;
    } rf_regs_t;

    rf_regs_t q, d;

    logic [ID_W-1:0]   id_shift;
    logic [LEN_W-1:0]  len_shift;
    logic [ADDR_W-1:0] addr_shift;
    logic [CNT_W-1:0]  cnt_shift;
    logic              op_known, op_addr, op_count, op_value;
    logic [LEN_W-1:0]  op_value_pos;
    logic              accept;

    rf_byte_shift #(.W(ID_W))   u_id_shift   (.cur(q.id),    .din(in_data), .nxt(id_shift));
    rf_byte_shift #(.W(LEN_W))  u_len_shift  (.cur(q.len),   .din(in_data), .nxt(len_shift));
    rf_byte_shift #(.W(ADDR_W)) u_addr_shift (.cur(q.addr),  .din(in_data), .nxt(addr_shift));
    rf_byte_shift #(.W(CNT_W))  u_cnt_shift  (.cur(q.count), .din(in_data), .nxt(cnt_shift));

    rf_op_layout #(
        .ID_W  (ID_W),
        .LEN_W (LEN_W),
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W)
    ) u_layout (
        .op_id    (q.id),
        .known    (op_known),
        .has_addr (op_addr),
        .has_count(op_count),
        .has_value(op_value),
        .value_pos(op_value_pos)
    );

    assign accept = in_valid && (q.state != ST_HOLD);

    always_comb begin
        d       = q;
        d.close = 1'b0;
        d.err   = 1'b0;
        unique case (q.state)
            ST_HUNT: begin
                if (accept) begin
                    if (in_data == RF_SOF) begin
                        d.state = ST_ID;
                        d.idx   = '0;
                        d.id    = '0;
                        d.len   = '0;
                        d.addr  = '0;
                        d.count = '0;
                        d.value = '0;
                    end else begin
                        d.close = 1'b1;
                    end
                end
            end
            ST_ID: begin
                if (accept) begin
                    d.id = id_shift;
                    if (q.idx == IDX_W'(ID_BYTES - 1)) begin
                        d.state = ST_LEN;
                        d.idx   = '0;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            ST_LEN: begin
                if (accept) begin
                    d.len = len_shift;
                    if (q.idx == IDX_W'(LEN_BYTES - 1)) begin
                        d.idx = '0;
                        d.pos = '0;
                        if (!op_known) begin
                            d.err   = 1'b1;
                            d.state = ST_HUNT;
                        end else if (len_shift == '0) begin
                            d.state = ST_TAIL;
                        end else begin
                            d.state = ST_BODY;
                        end
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            ST_BODY: begin
                if (accept) begin
                    if (op_addr && q.pos < LEN_W'(ADDR_BYTES))
                        d.addr = addr_shift;
                    if (op_count && q.pos >= LEN_W'(ADDR_BYTES)
                                 && q.pos < LEN_W'(ADDR_BYTES + CNT_BYTES))
                        d.count = cnt_shift;
                    if (op_value && q.pos == op_value_pos)
                        d.value = VAL_W'(in_data);
                    d.pos = q.pos + 1'b1;
                    if (q.pos == q.len - 1'b1)
                        d.state = ST_TAIL;
                end
            end
            ST_TAIL: begin
                if (accept) begin
                    if (in_data == RF_EOF) begin
                        d.state = ST_HOLD;
                    end else begin
                        d.err   = 1'b1;
                        d.state = ST_HUNT;
                    end
                end
            end
            ST_HOLD: begin
                if (req_ack)
                    d.state = ST_HUNT;
            end
            default: d.state = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_HUNT;
        end else begin
            q <= d;
        end
    end

    assign in_ready   = (q.state != ST_HOLD);
    assign req_valid  = (q.state == ST_HOLD);
    assign req_id     = q.id;
    assign req_addr   = q.addr;
    assign req_count  = q.count;
    assign req_value  = q.value;
    assign close_conn = q.close;
    assign proto_err  = q.err;

endmodule

// File: rtl/rf_parser_chk.sv
module rf_parser_chk #(
    parameter int ID_W   = 32,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32,
    parameter int VAL_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [7:0]        in_data,
    input logic              in_ready,
    input logic              req_valid,
    input logic              req_ack,
    input logic [ID_W-1:0]   req_id,
    input logic [ADDR_W-1:0] req_addr,
    input logic [CNT_W-1:0]  req_count,
    input logic [VAL_W-1:0]  req_value,
    input logic              close_conn,
    input logic              proto_err
);
    // R11
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack) |=> (req_valid && $stable(req_id) && $stable(req_addr)
                                     && $stable(req_count) && $stable(req_value)));

    // R11
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !in_ready);

    // R2
    close_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        close_conn |-> $past(in_valid && in_ready && in_data != 8'hA5));

    // R2
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(close_conn && proto_err));

    // R9
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> $past(in_valid && in_ready));

    // R11
    req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> $past(in_valid && in_ready && in_data == 8'h5A));

endmodule

bind req_frame_parser rf_parser_chk #(
    .ID_W  (ID_W),
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W),
    .VAL_W (VAL_W)
) u_rf_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .req_valid (req_valid),
    .req_ack   (req_ack),
    .req_id    (req_id),
    .req_addr  (req_addr),
    .req_count (req_count),
    .req_value (req_value),
    .close_conn(close_conn),
    .proto_err (proto_err)
);

// File: tb/test_req_frame_parser.sv
module test_req_frame_parser;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready;
    logic        req_valid;
    logic        req_ack = 1'b0;
    logic [31:0] req_id;
    logic [31:0] req_addr;
    logic [31:0] req_count;
    logic [7:0]  req_value;
    logic        close_conn;
    logic        proto_err;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    req_frame_parser i_req_frame_parser (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .req_valid (req_valid),
        .req_ack   (req_ack),
        .req_id    (req_id),
        .req_addr  (req_addr),
        .req_count (req_count),
        .req_value (req_value),
        .close_conn(close_conn),
        .proto_err (proto_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Offer one byte for one rising edge; returns at the falling edge after it.
    task automatic put(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic put32(input logic [31:0] w);
        for (int k = 3; k >= 0; k--) put(w[k*8 +: 8]);
    endtask

    task automatic ack_req(input string tag);
        @(negedge clk);
        req_ack = 1'b1;
        @(negedge clk);
        req_ack = 1'b0;
        check({tag, " valid after ack"}, 32'(req_valid), 32'd0);
        check({tag, " ready after ack"}, 32'(in_ready), 32'd1);
    endtask

    function automatic logic [7:0] pat(input int op, input int i);
        return 8'((op * 13 + i * 7 + 1) & 8'h7F);
    endfunction

    function automatic int len_of(input int li);
        case (li)
            0: return 0;
            1: return 1;
            2: return 4;
            3: return 5;
            4: return 8;
            5: return 9;
            default: return 12;
        endcase
    endfunction

    function automatic string tag_of(input int op, input int len);
        if (len == 0) return "R12";
        case (op)
            1, 5:    return "R4";
            2:       return "R5";
            3:       return "R6";
            10:      return "R7";
            default: return "R8";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] ea, ec, eid;
        logic [7:0]  ev;
        string       t;

        repeat (3) @(negedge clk);
        // R1
        check("R1 in_ready", 32'(in_ready), 32'd1);
        check("R1 req_valid", 32'(req_valid), 32'd0);
        check("R1 close_conn", 32'(close_conn), 32'd0);
        check("R1 proto_err", 32'(proto_err), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: bad start bytes
        put(8'h00);
        check("R2 close pulse", 32'(close_conn), 32'd1);
        check("R2 no error", 32'(proto_err), 32'd0);
        @(negedge clk);
        check("R2 pulse one cycle", 32'(close_conn), 32'd0);
        put(8'h5A);
        check("R2 close on end byte", 32'(close_conn), 32'd1);

        // Sweep: identifiers 0..10 plus one unknown, several lengths
        for (int op = 0; op < 12; op++) begin
            for (int li = 0; li < 7; li++) begin
                int len;
                len = len_of(li);
                eid = (op == 11) ? 32'h0001_000B : 32'(op);
                put(8'hA5);
                put32(eid);
                put32(32'(len));
                if (op == 11) begin
                    // R10
                    check("R10 error after length", 32'(proto_err), 32'd1);
                    check("R10 no request", 32'(req_valid), 32'd0);
                    @(negedge clk);
                    check("R10 pulse one cycle", 32'(proto_err), 32'd0);
                end else begin
                    ea = '0; ec = '0; ev = '0;
                    for (int i = 0; i < len; i++) begin
                        logic [7:0] b;
                        b = pat(op, i);
                        put(b);
                        if ((op == 1 || op == 2 || op == 3 || op == 5 || op == 10) && i < 4)
                            ea = {ea[23:0], b};
                        if ((op == 3 || op == 10) && i >= 4 && i < 8)
                            ec = {ec[23:0], b};
                        if ((op == 1 || op == 5) && i == 4) ev = b;
                        if (op == 10 && i == 8) ev = b;
                    end
                    check("R11 not early", 32'(req_valid), 32'd0);
                    put(8'h5A);
                    t = tag_of(op, len);
                    check({t, " valid"}, 32'(req_valid), 32'd1);
                    check("R3 id", req_id, eid);
                    check({t, " addr"}, req_addr, ea);
                    check({t, " count"}, req_count, ec);
                    check({t, " value"}, 32'(req_value), 32'(ev));
                    ack_req(t);
                end
            end
        end

        // R9: wrong end byte
        put(8'hA5);
        put32(32'd2);
        put32(32'd4);
        put32(32'h1122_3344);
        put(8'h33);
        check("R9 error pulse", 32'(proto_err), 32'd1);
        check("R9 no request", 32'(req_valid), 32'd0);
        @(negedge clk);
        check("R9 pulse one cycle", 32'(proto_err), 32'd0);
        put(8'hA5);
        check("R9 back to hunt", 32'(close_conn), 32'd0);
        put32(32'd0);
        put32(32'd0);
        put(8'h5A);
        check("R9 recovers", 32'(req_valid), 32'd1);
        check("R9 recovered id", req_id, 32'd0);
        ack_req("R9");

        // R11: hold with bytes offered, then check nothing was consumed
        put(8'hA5);
        put32(32'd1);
        put32(32'd5);
        put32(32'hDEAD_BEEF);
        put(8'h42);
        put(8'h5A);
        check("R11 valid", 32'(req_valid), 32'd1);
        check("R11 stall", 32'(in_ready), 32'd0);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 8'h07;
        repeat (4) @(negedge clk);
        in_valid = 1'b0;
        check("R11 still valid", 32'(req_valid), 32'd1);
        check("R11 addr held", req_addr, 32'hDEAD_BEEF);
        check("R11 value held", 32'(req_value), 32'h42);
        check("R11 no close during hold", 32'(close_conn), 32'd0);
        ack_req("R11");
        put(8'hA5);
        check("R11 junk not consumed", 32'(close_conn), 32'd0);
        put32(32'd2);
        put32(32'd4);
        put32(32'h0A0B_0C0D);
        put(8'h5A);
        check("R11 next request", 32'(req_valid), 32'd1);
        check("R11 next addr", req_addr, 32'h0A0B_0C0D);
        ack_req("R11");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule